// File: doc/BRIEF.md
# Serial EEPROM Identification Autoloader

This block sits beside the bus configuration registers and fills them with identification words kept in an optional external serial EEPROM. The EEPROM is a three-wire part with a chip select. After reset, the block first releases the chip-select pin and listens to it for a short window. A board that fits the EEPROM also fits a pull-up on that line, so a high level means the part is present. If the part is missing, the built-in default identification words are kept. If it is present, the block issues one read command per word on a serial clock that runs at the bus clock divided by a parameter (256 by default). It shifts the returned bits in, most significant first, and places each word on its own slice of the identification output.

Four words are fetched, from EEPROM addresses 0 to 3: the vendor identifier, the device identifier, the subsystem vendor identifier and the subsystem identifier. Until the load has finished, a configuration read is answered with a retry indication. Once the load is over, software owns the four EEPROM lines through a small manual register and can drive them bit by bit. This leaves the unused EEPROM space free for general storage.

Top module: `eeprom_id_loader`

## Requirements
- R1: While reset is asserted and during the sensing window after it, `loadDone` is 0, `eeCsOe` is 0, `eeSclk` and `eeDin` are 0, and `idWords` holds `DEFAULT_IDS`.
- R2: After reset, the chip-select driver stays off for `SENSE_CYCLES` (16) clock edges, and `eeCsSense` is sampled on the last of them. If it reads 1, a load starts. If it reads 0, `loadDone` rises on that edge, `idWords` keeps its defaults and no serial clock pulse is produced.
- R3: During a load, `eeSclk` has a period of exactly `CLK_DIV` (256) bus clocks and is high for the second half of each period (128 clocks).
- R4: Each word frame sends 9 command bits on `eeDin`, which the EEPROM takes on the rising serial clock edges 1 to 9: the start bit 1, the opcode bits 1 then 0, and then the 6-bit word address, most significant bit first. The frames address 0, 1, 2 and 3 in that order.
- R5: On rising serial edges 10 to 25 of a frame, `eeDout` is sampled. The first bit sampled becomes bit 15 of the word and the last becomes bit 0.
- R6: The word read from address k is placed at `idWords[16k+15:16k]`: k=0 is the vendor ID, k=1 the device ID, k=2 the subsystem vendor ID and k=3 the subsystem ID. After `loadDone`, `idWords` does not change.
- R7: In each frame, `eeCsOut` is high for 26 serial periods and carries exactly 25 serial clock pulses. It then stays low for exactly one serial period (256 clocks) before the next frame, and no serial clock pulse occurs while it is low.
- R8: With the EEPROM present, `loadDone` rises on clock edge 16 + 4*27*256 = 27664 after reset is released, and it stays at 1 until the next reset.
- R9: `cfgRetry` is 1 exactly when `cfgRdReq` is 1 and `loadDone` is 0.
- R10: A `manWrEn` write before `loadDone` has no effect. After `loadDone`, a write drives `manWrData[0]` to `eeCsOut`, `manWrData[1]` to `eeSclk` and `manWrData[2]` to `eeDin`, starting on the clock after the write.
- R11: `manRdData` returns {live `eeDout`, stored data-in bit, stored clock bit, stored chip-select bit}, with bit 3 following `eeDout` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| eeCsOut | output | 1 | Chip select driven to the EEPROM |
| eeCsOe | output | 1 | Chip-select driver enable; 0 while sensing presence |
| eeCsSense | input | 1 | Level read back from the chip-select pin |
| eeSclk | output | 1 | Serial clock to the EEPROM |
| eeDin | output | 1 | Serial data into the EEPROM |
| eeDout | input | 1 | Serial data out of the EEPROM |
| manWrEn | input | 1 | Write strobe for the manual pin register |
| manWrData | input | 3 | Manual levels {data-in, clock, chip select} |
| manRdData | output | 4 | {eeDout, data-in, clock, chip select} read-back |
| cfgRdReq | input | 1 | A configuration read is being presented |
| cfgRetry | output | 1 | Tells the bus to retry the read; the load is not yet done |
| loadDone | output | 1 | Identification words are final |
| idWords | output | NUM_WORDS*WORD_W | Identification words, word k at bits [16k+15:16k] |

## Verification
The bench aims at the frame boundaries. A command bit shifted one serial period late would put address 1 where address 0 belongs, so the bench records the nine bits the EEPROM model actually received in every frame. A data shift register that samples on the falling edge, or one edge too early, would return each word rotated by a bit, so the bench checks the four stored words against values whose end bits differ. It measures the serial period, the high time and the chip-select gap, since a divider that is off by one would stretch all three. It also checks the path with no EEPROM fitted and the manual writes sent during a load, which must be ignored: a presence test with the wrong sense would start a load with no part fitted, and an unguarded manual register would corrupt the pins.

// File: rtl/eeld_pkg.sv
package eeld_pkg;

  typedef enum logic [1:0] {
    ST_SENSE  = 2'd0,
    ST_LOAD   = 2'd1,
    ST_MANUAL = 2'd2
  } ldState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic divRun;
    logic csAct;
    logic clkGate;
    logic cmdPhase;
    logic cmdLoad;
    logic cmdStep;
    logic dataSample;
    logic wordStore;
    logic manualOwn;
  } ldStrobe_t;

  // start bit, then read opcode
  localparam logic [2:0] READ_PREFIX = 3'b110;

endpackage

// File: rtl/eeld_control.sv
module eeld_control
  import eeld_pkg::*;
#(
  parameter int NUM_WORDS    = 4,
  parameter int ADDR_W       = 6,
  parameter int WORD_W       = 16,
  parameter int SENSE_CYCLES = 16,
  localparam int WIDX_W      = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickRise,
  input  logic              tickEnd,
  input  logic              csSense,
  output ldStrobe_t         ctl,
  output logic [WIDX_W-1:0] wordIdx,
  output logic              loadDone,
  output logic              csOe
);

  localparam int CMD_BITS   = 3 + ADDR_W;
  localparam int FIRST_DATA = CMD_BITS + 1;
  localparam int LAST_DATA  = CMD_BITS + WORD_W;
  localparam int GAP_SLOT   = LAST_DATA + 1;
  localparam int SLOT_W     = $clog2(GAP_SLOT + 1);
  localparam int SENSE_W    = $clog2(SENSE_CYCLES + 1);

  ldState_e           state;
  logic [SLOT_W-1:0]  slotIdx;
  logic [SENSE_W-1:0] senseCnt;
  logic               inLoad;
  logic               lastWord;

  assign inLoad   = (state == ST_LOAD);
  assign lastWord = (wordIdx == WIDX_W'(NUM_WORDS - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_SENSE;
      slotIdx  <= '0;
      wordIdx  <= '0;
      senseCnt <= '0;
    end else begin
      unique case (state)
        ST_SENSE: begin
          if (senseCnt == SENSE_W'(SENSE_CYCLES - 1)) begin
            state <= csSense ? ST_LOAD : ST_MANUAL;
          end else begin
            senseCnt <= senseCnt + 1'b1;
          end
        end
        ST_LOAD: begin
          if (tickEnd) begin
            if (slotIdx == SLOT_W'(GAP_SLOT)) begin
              slotIdx <= '0;
              if (lastWord) state <= ST_MANUAL;
              else          wordIdx <= wordIdx + 1'b1;
            end else begin
              slotIdx <= slotIdx + 1'b1;
            end
          end
        end
        default: state <= ST_MANUAL;
      endcase
    end
  end

  always_comb begin
    ctl            = '0;
    ctl.divRun     = inLoad;
    ctl.csAct      = inLoad && (slotIdx != SLOT_W'(GAP_SLOT));
    ctl.clkGate    = inLoad && (slotIdx >= SLOT_W'(1)) && (slotIdx <= SLOT_W'(LAST_DATA));
    ctl.cmdPhase   = inLoad && (slotIdx >= SLOT_W'(1)) && (slotIdx <= SLOT_W'(CMD_BITS));
    ctl.cmdLoad    = inLoad && tickEnd && (slotIdx == '0);
    ctl.cmdStep    = inLoad && tickEnd && (slotIdx >= SLOT_W'(1)) && (slotIdx < SLOT_W'(CMD_BITS));
    ctl.dataSample = inLoad && tickRise && (slotIdx >= SLOT_W'(FIRST_DATA)) &&
                     (slotIdx <= SLOT_W'(LAST_DATA));
    ctl.wordStore  = inLoad && tickEnd && (slotIdx == SLOT_W'(LAST_DATA));
    ctl.manualOwn  = (state == ST_MANUAL);
  end

  assign loadDone = ctl.manualOwn;
  assign csOe     = (state != ST_SENSE);

  // R8: completion is sticky until reset
  p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    loadDone |=> loadDone);

  // R7: slot position only advances on a serial period boundary
  p_slot_on_tick_r7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(slotIdx) |-> $past(tickEnd));

  // R4: word address only moves at the end of a frame gap
  p_word_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(wordIdx) |-> ($past(slotIdx) == SLOT_W'(GAP_SLOT)));

endmodule

// File: rtl/eeld_datapath.sv
module eeld_datapath
  import eeld_pkg::*;
#(
  parameter int CLK_DIV                       = 256,
  parameter int NUM_WORDS                     = 4,
  parameter int ADDR_W                        = 6,
  parameter int WORD_W                        = 16,
  parameter logic [NUM_WORDS*WORD_W-1:0] DEFAULT_IDS = '0,
  localparam int WIDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ldStrobe_t                     ctl,
  input  logic [WIDX_W-1:0]             wordIdx,
  input  logic                          eeDout,
  input  logic                          manWrEn,
  input  logic [2:0]                    manWrData,
  output logic                          tickRise,
  output logic                          tickEnd,
  output logic                          eeCsOut,
  output logic                          eeSclk,
  output logic                          eeDin,
  output logic [3:0]                    manRdData,
  output logic [NUM_WORDS*WORD_W-1:0]   idWords
);

  localparam int DIV_W    = $clog2(CLK_DIV);
  localparam int HALF     = CLK_DIV / 2;
  localparam int CMD_BITS = 3 + ADDR_W;

  logic [DIV_W-1:0]    divCnt;
  logic                sclkQ;
  logic [CMD_BITS-1:0] cmdReg;
  logic [WORD_W-1:0]   dataReg;
  logic [2:0]          manReg;   // {din, sclk, cs}

  // Serial clock divider
  assign tickRise = ctl.divRun && (divCnt == DIV_W'(HALF - 1));
  assign tickEnd  = ctl.divRun && (divCnt == DIV_W'(CLK_DIV - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              divCnt <= '0;
    else if (!ctl.divRun)   divCnt <= '0;
    else if (tickEnd)       divCnt <= '0;
    else                    divCnt <= divCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          sclkQ <= 1'b0;
    else if (!ctl.divRun || tickEnd)    sclkQ <= 1'b0;
    else if (tickRise && ctl.clkGate)   sclkQ <= 1'b1;
  end

  // Command shifter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cmdReg <= '0;
    else if (ctl.cmdLoad) cmdReg <= {READ_PREFIX, ADDR_W'(wordIdx)};
    else if (ctl.cmdStep) cmdReg <= {cmdReg[CMD_BITS-2:0], 1'b0};
  end

  // Data shifter, MSB first
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               dataReg <= '0;
    else if (ctl.dataSample) dataReg <= {dataReg[WORD_W-2:0], eeDout};
  end

  // Identification word storage
  for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
    logic [WORD_W-1:0] wordQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) wordQ <= DEFAULT_IDS[k*WORD_W +: WORD_W];
      else if (ctl.wordStore && (wordIdx == WIDX_W'(k))) wordQ <= dataReg;
    end
    assign idWords[k*WORD_W +: WORD_W] = wordQ;
  end

  // Manual pin register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           manReg <= '0;
    else if (ctl.manualOwn && manWrEn)   manReg <= manWrData;
  end

  assign eeCsOut   = ctl.manualOwn ? manReg[0] : ctl.csAct;
  assign eeSclk    = ctl.manualOwn ? manReg[1] : sclkQ;
  assign eeDin     = ctl.manualOwn ? manReg[2] : (ctl.cmdPhase & cmdReg[CMD_BITS-1]);
  assign manRdData = {eeDout, manReg};

  // R7: automatic serial clock only pulses inside a chip-select frame
  p_sclk_in_frame_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.manualOwn && sclkQ) |-> ctl.csAct);

  // R3: rising serial edge lands at the half-period point
  p_sclk_half_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(sclkQ) && !ctl.manualOwn) |-> (divCnt == DIV_W'(HALF)));

  // R6: words are frozen once software owns the pins
  p_ids_frozen_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.manualOwn |=> $stable(idWords));

  // R10: manual register untouched before the load completes
  p_manual_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.manualOwn |-> (manReg == 3'b000));

endmodule

// File: rtl/eeprom_id_loader.sv
module eeprom_id_loader
  import eeld_pkg::*;
#(
  parameter int CLK_DIV      = 256,
  parameter int NUM_WORDS    = 4,
  parameter int ADDR_W       = 6,
  parameter int WORD_W       = 16,
  parameter int SENSE_CYCLES = 16,
  parameter logic [NUM_WORDS*WORD_W-1:0] DEFAULT_IDS = 64'h0000_0000_1D2E_7A31
) (
  input  logic                        clk,
  input  logic                        rstN,
  output logic                        eeCsOut,
  output logic                        eeCsOe,
  input  logic                        eeCsSense,
  output logic                        eeSclk,
  output logic                        eeDin,
  input  logic                        eeDout,
  input  logic                        manWrEn,
  input  logic [2:0]                  manWrData,
  output logic [3:0]                  manRdData,
  input  logic                        cfgRdReq,
  output logic                        cfgRetry,
  output logic                        loadDone,
  output logic [NUM_WORDS*WORD_W-1:0] idWords
);

  localparam int WIDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

  ldStrobe_t         ctl;
  logic [WIDX_W-1:0] wordIdx;
  logic              tickRise;
  logic              tickEnd;

  eeld_control #(
    .NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W), .WORD_W(WORD_W), .SENSE_CYCLES(SENSE_CYCLES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .tickRise(tickRise), .tickEnd(tickEnd),
    .csSense(eeCsSense), .ctl(ctl), .wordIdx(wordIdx),
    .loadDone(loadDone), .csOe(eeCsOe)
  );

  eeld_datapath #(
    .CLK_DIV(CLK_DIV), .NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W), .WORD_W(WORD_W),
    .DEFAULT_IDS(DEFAULT_IDS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wordIdx(wordIdx), .eeDout(eeDout),
    .manWrEn(manWrEn), .manWrData(manWrData), .tickRise(tickRise), .tickEnd(tickEnd),
    .eeCsOut(eeCsOut), .eeSclk(eeSclk), .eeDin(eeDin), .manRdData(manRdData),
    .idWords(idWords)
  );

  assign cfgRetry = cfgRdReq & ~loadDone;

endmodule

// File: tb/sim_eeprom_id_loader.sv
module sim_eeprom_id_loader;

  localparam logic [63:0] DEFS = 64'h0000_0000_1D2E_7A31;
  localparam int LOAD_EDGES = 16 + 4 * 27 * 256;

  // {wr[2:0], dout, expected read-back[3:0]}
  localparam logic [7:0] MAN_VEC [8] = '{
    8'b001_0_0001, 8'b010_1_1010, 8'b100_0_0100, 8'b111_1_1111,
    8'b000_1_1000, 8'b101_0_0101, 8'b011_1_1011, 8'b000_0_0000
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic eeCsOut, eeCsOe, eeCsSense, eeSclk, eeDin, eeDout;
  logic manWrEn = 1'b0;
  logic [2:0] manWrData = '0;
  logic [3:0] manRdData;
  logic cfgRdReq = 1'b0;
  logic cfgRetry, loadDone;
  logic [63:0] idWords;

  logic pullPresent = 1'b1;
  logic modelOn = 1'b1;
  logic modelDout = 1'b0;
  logic tbDout = 1'b0;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  assign eeCsSense = eeCsOe ? eeCsOut : pullPresent;
  assign eeDout    = modelOn ? modelDout : tbDout;

  eeprom_id_loader u0 (
    .clk(clk), .rstN(rstN), .eeCsOut(eeCsOut), .eeCsOe(eeCsOe), .eeCsSense(eeCsSense),
    .eeSclk(eeSclk), .eeDin(eeDin), .eeDout(eeDout), .manWrEn(manWrEn),
    .manWrData(manWrData), .manRdData(manRdData), .cfgRdReq(cfgRdReq),
    .cfgRetry(cfgRetry), .loadDone(loadDone), .idWords(idWords)
  );

  // EEPROM model
  logic [15:0] mem [4];
  logic [8:0]  cmdBits = '0;
  logic [8:0]  rxCmd [4];
  int          rxRises [4];
  int          rises = 0;
  int          frameCnt = 0;

  initial begin
    mem[0] = 16'h8421; mem[1] = 16'h5AA5; mem[2] = 16'hF00F; mem[3] = 16'h0137;
    for (int i = 0; i < 4; i++) begin rxCmd[i] = '0; rxRises[i] = 0; end
  end

  always @(posedge eeSclk) if (modelOn && eeCsOut) begin
    if (rises < 9) cmdBits = {cmdBits[7:0], eeDin};
    rises = rises + 1;
  end

  always @(negedge eeSclk) if (modelOn && eeCsOut && rises >= 9 && rises < 25)
    modelDout = mem[cmdBits[1:0]][24 - rises];

  always @(posedge eeCsOut) if (modelOn) begin rises = 0; cmdBits = '0; end

  always @(negedge eeCsOut) if (modelOn && frameCnt < 4) begin
    rxCmd[frameCnt] = cmdBits;
    rxRises[frameCnt] = rises;
    frameCnt = frameCnt + 1;
  end

  // Serial timing monitor
  int cyc = 0, lastRise = -1, riseCyc = -1, periodMeas = -1, highMeas = -1;
  int csFallCyc = -1, gapMeas = -1, strayRises = 0, totalRises = 0;
  logic prevSclk = 1'b0, prevCs = 1'b0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (eeSclk && !prevSclk && !loadDone) begin
      totalRises = totalRises + 1;
      if (!eeCsOut) strayRises = strayRises + 1;
      if (lastRise >= 0 && periodMeas < 0) periodMeas = cyc - lastRise;
      lastRise = cyc;
      riseCyc = cyc;
    end
    if (!eeSclk && prevSclk && highMeas < 0 && riseCyc >= 0) highMeas = cyc - riseCyc;
    if (!eeCsOut && prevCs && !loadDone) csFallCyc = cyc;
    if (eeCsOut && !prevCs && csFallCyc >= 0 && gapMeas < 0) gapMeas = cyc - csFallCyc;
    prevSclk = eeSclk;
    prevCs = eeCsOut;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n;
    // R1: reset state
    repeat (4) @(negedge clk);
    chk("R1 done in reset", {63'd0, loadDone}, 64'd0);
    chk("R1 oe in reset", {63'd0, eeCsOe}, 64'd0);
    chk("R1 pins in reset", {62'd0, eeSclk, eeDin}, 64'd0);
    chk("R1 ids in reset", idWords, DEFS);
    rstN = 1'b1;

    // Load with EEPROM present
    n = 0;
    while (n < 40000) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (n == 8) chk("R1 oe while sensing", {63'd0, eeCsOe}, 64'd0);
      if (n == 100) begin manWrEn = 1'b1; manWrData = 3'b111; end
      if (n == 101) manWrEn = 1'b0;
      if (n == 102) chk("R10 write ignored during load", {60'd0, manRdData[2:0]}, 64'd0);
      if (n == 200) cfgRdReq = 1'b1;
      if (n == 201) begin
        chk("R9 retry while loading", {63'd0, cfgRetry}, 64'd1);
        cfgRdReq = 1'b0;
      end
      if (n == 202) chk("R9 no retry without request", {63'd0, cfgRetry}, 64'd0);
      if (loadDone) break;
    end
    chk("R8 done edge", 64'(n), 64'(LOAD_EDGES));

    for (int k = 0; k < 4; k++) begin
      chk("R4 command frame", {55'd0, rxCmd[k]}, {55'd0, 3'b110, 6'(k)});
      chk("R7 pulses per frame", 64'(rxRises[k]), 64'd25);
      chk("R5 R6 word slice", {48'd0, idWords[k*16 +: 16]}, {48'd0, mem[k]});
    end
    chk("R3 serial period", 64'(periodMeas), 64'd256);
    chk("R3 serial high time", 64'(highMeas), 64'd128);
    chk("R7 chip-select gap", 64'(gapMeas), 64'd256);
    chk("R7 stray pulses", 64'(strayRises), 64'd0);

    // Manual mode vectors (R10, R11)
    modelOn = 1'b0;
    for (int v = 0; v < 8; v++) begin
      manWrEn = 1'b1;
      manWrData = MAN_VEC[v][7:5];
      @(negedge clk);
      manWrEn = 1'b0;
      tbDout = MAN_VEC[v][4];
      #1;
      chk("R10 manual pins", {61'd0, eeDin, eeSclk, eeCsOut}, {61'd0, MAN_VEC[v][2:0]});
      chk("R11 manual read-back", {60'd0, manRdData}, {60'd0, MAN_VEC[v][3:0]});
      @(negedge clk);
    end
    chk("R6 ids frozen", idWords, {mem[3], mem[2], mem[1], mem[0]});
    chk("R8 done held", {63'd0, loadDone}, 64'd1);
    cfgRdReq = 1'b1;
    @(negedge clk);
    chk("R9 no retry after done", {63'd0, cfgRetry}, 64'd0);
    cfgRdReq = 1'b0;

    // Second reset, EEPROM absent
    pullPresent = 1'b0;
    rstN = 1'b0;
    totalRises = 0;
    repeat (3) @(negedge clk);
    chk("R1 done cleared by reset", {63'd0, loadDone}, 64'd0);
    chk("R1 ids back to defaults", idWords, DEFS);
    rstN = 1'b1;
    n = 0;
    while (n < 100) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (loadDone) break;
    end
    chk("R2 absent done edge", 64'(n), 64'd16);
    chk("R2 absent keeps defaults", idWords, DEFS);
    chk("R2 absent no pulses", 64'(totalRises), 64'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule